// File: doc/BRIEF.md
# Conversion Result Byte Bus Interface

This block sits between the counter stage of an integrating analog-to-digital converter and a narrow host bus. It holds one conversion result: a 15-bit magnitude, a sign flag and an out-of-range flag. The result is latched on a one-cycle strobe from the converter. The block returns the result one byte at a time over an 8-bit data bus. The tri-state driver is modelled as a data vector plus a drive-enable output. The bus is driven only when three host inputs agree: an active-high select, an active-low enable and an active-low read strobe.

The block has two access styles, chosen by a mode input.
- **Addressed style.** The host picks the byte with a byte-select input. When the upper byte is picked, a second input decides whether bit 7 carries the sign flag or the out-of-range flag. Bytes may be read in any order, and the result is held until the converter latches a new one.
- **Streaming style.** Both select inputs are ignored. An internal three-step pointer hands out the upper byte with the sign flag, then the lower byte, then the upper byte with the out-of-range flag. The pointer advances when the read strobe is released. If the host has not collected the result within a fixed number of internal clocks after the latch, the result is cleared and the pointer returns to its first step.

All host inputs pass through a synchroniser before they are used. A host access therefore takes effect a fixed number of clocks after the inputs change.

Top module: `conv_result_bus`

## Requirements
- R1: `dataOe` is 1 only when the synchronised `csHi`=1, `ceN`=0 and `rdN`=0; otherwise `dataOe`=0 and `dataOut` is 8'h00.
- R2: In addressed style (`contMode`=0) with `byteSelLo`=1, `dataOut` equals magnitude bits 7..0.
- R3: In addressed style with `byteSelLo`=0, `dataOut[6:0]` equals magnitude bits 14..8. `dataOut[7]` is the sign flag (1 = positive) when `dbSelOvr`=0, and the out-of-range flag (1 = over) when `dbSelOvr`=1.
- R4: In streaming style (`contMode`=1), successive reads return {sign, mag[14:8]}, then mag[7:0], then {overrange, mag[14:8]}, then wrap to the first byte. `byteSelLo` and `dbSelOvr` have no effect.
- R5: In streaming style, the pointer advances once per 0-to-1 transition of the synchronised `rdN`, and only while the block is selected. Holding `rdN` low does not advance it, and a read pulse while deselected does not advance it.
- R6: A `resultValid` pulse latches `resultMag`, `resultPos` and `resultOvr` on that clock edge and returns the streaming pointer to its first byte.
- R7: In streaming style, `EXPIRE_CYCLES` clocks after a latch, the held result is cleared to zero and the pointer returns to its first byte. In addressed style the result is held indefinitely.
- R8: A change on a host input reaches the outputs `SYNC_STAGES` clock edges later, and not earlier.
- R9: After reset, `dataOe`=0, the held result is zero and the pointer is at its first byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal conversion clock |
| rstN | input | 1 | Asynchronous active-low reset |
| resultValid | input | 1 | One-cycle strobe: a new result is ready |
| resultMag | input | 15 | Result magnitude |
| resultPos | input | 1 | Sign flag, 1 = positive |
| resultOvr | input | 1 | Out-of-range flag, 1 = over full scale |
| csHi | input | 1 | Host select, active high |
| ceN | input | 1 | Host enable, active low |
| rdN | input | 1 | Host read strobe, active low |
| contMode | input | 1 | 1 = streaming style, 0 = addressed style |
| byteSelLo | input | 1 | Addressed style: 1 = lower byte, 0 = upper byte |
| dbSelOvr | input | 1 | Addressed style, upper byte: 1 = bit 7 is out-of-range, 0 = bit 7 is sign |
| dataOut | output | 8 | Data presented to the bus, 0 when not driven |
| dataOe | output | 1 | Bus drive enable |

## Verification
The streaming pointer and the expiry timer are invisible state that the host only sees through the byte a read returns. A pointer that slipped or failed to clear shows up as the wrong byte at the next read, about `SYNC_STAGES` clocks after the strobe falls. A latch that is cleared too early or too late shows up as zero bytes, or as stale bytes, on the first read after the deadline. A reference model compares `dataOe` and `dataOut` on every clock, so a fault shows up in the first cycle it reaches a port. Named checks pin the byte orders and flag positions to literal values.

// File: rtl/conv_bus_pkg.sv
package conv_bus_pkg;

  // Which byte the mux should present; encodings 0..2 match the streaming order.
  typedef enum logic [1:0] {
    KIND_HI_POL = 2'd0,
    KIND_LO     = 2'd1,
    KIND_HI_OVR = 2'd2
  } byteKind_e;

  // Strobes passed from control to datapath each cycle.
  typedef struct packed {
    logic      capture;
    logic      expire;
    logic      busOe;
    byteKind_e kind;
  } busCtrl_t;

endpackage

// File: rtl/bus_seq_ctrl.sv
module bus_seq_ctrl
  import conv_bus_pkg::*;
#(
  parameter int SYNC_STAGES   = 2,
  parameter int EXPIRE_CYCLES = 443
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     resultValid,
  input  logic     csHi,
  input  logic     ceN,
  input  logic     rdN,
  input  logic     contMode,
  input  logic     byteSelLo,
  input  logic     dbSelOvr,
  output busCtrl_t ctrl
);

  localparam int NSIG  = 6;
  localparam int AGE_W = $clog2(EXPIRE_CYCLES + 1);
  localparam logic [AGE_W-1:0] AGE_LAST = AGE_W'(EXPIRE_CYCLES - 1);
  // idle levels, order {cs, ceN, rdN, cont, bsel, dsel}
  localparam logic [NSIG-1:0] IDLE_VEC = 6'b011000;

  logic [NSIG-1:0] rawVec;
  logic [SYNC_STAGES-1:0][NSIG-1:0] syncPipe;
  logic [NSIG-1:0] syncVec;

  assign rawVec  = {csHi, ceN, rdN, contMode, byteSelLo, dbSelOvr};
  assign syncVec = syncPipe[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncPipe <= {SYNC_STAGES{IDLE_VEC}};
    else       syncPipe <= {syncPipe[SYNC_STAGES-2:0], rawVec};
  end

  logic sCs, sCeN, sRdN, sCont, sBsel, sDsel;
  assign {sCs, sCeN, sRdN, sCont, sBsel, sDsel} = syncVec;

  logic selected, rdPrev, rdRise;
  assign selected = sCs & ~sCeN;
  assign rdRise   = sRdN & ~rdPrev & selected & sCont;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdPrev <= 1'b1;
    else       rdPrev <= sRdN;
  end

  // age of the held result, saturating at the last count
  logic [AGE_W-1:0] ageCnt;
  logic live, expireHit;
  assign expireHit = live & sCont & (ageCnt == AGE_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ageCnt <= '0;
      live   <= 1'b0;
    end else if (resultValid) begin
      ageCnt <= '0;
      live   <= 1'b1;
    end else if (expireHit) begin
      live   <= 1'b0;
    end else if (live && ageCnt != AGE_LAST) begin
      ageCnt <= ageCnt + 1'b1;
    end
  end

  logic [1:0] seqIdx;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                       seqIdx <= 2'd0;
    else if (resultValid || expireHit) seqIdx <= 2'd0;
    else if (rdRise)                 seqIdx <= (seqIdx == 2'd2) ? 2'd0 : seqIdx + 2'd1;
  end

  byteKind_e kindSel;
  always_comb begin
    if (sCont)      kindSel = byteKind_e'(seqIdx);
    else if (sBsel) kindSel = KIND_LO;
    else if (sDsel) kindSel = KIND_HI_OVR;
    else            kindSel = KIND_HI_POL;
  end

  assign ctrl.capture = resultValid;
  assign ctrl.expire  = expireHit;
  assign ctrl.busOe   = selected & ~sRdN;
  assign ctrl.kind    = kindSel;

  // R4
  seq_idx_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    seqIdx != 2'd3);

  // R6
  capture_resets_seq_chk: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |=> seqIdx == 2'd0);

  // R7
  age_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    ageCnt <= AGE_LAST);

  // R5
  held_read_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!sRdN && !resultValid && !expireHit) |=> $stable(seqIdx));

endmodule

// File: rtl/bus_result_dp.sv
module bus_result_dp
  import conv_bus_pkg::*;
#(
  parameter int BUS_W = 8,
  parameter int MAG_W = 15
) (
  input  logic             clk,
  input  logic             rstN,
  input  busCtrl_t         ctrl,
  input  logic [MAG_W-1:0] resMag,
  input  logic             resPos,
  input  logic             resOvr,
  output logic [BUS_W-1:0] dataOut,
  output logic             dataOe
);

  localparam int HI_W = MAG_W - BUS_W;

  logic [MAG_W-1:0] magQ;
  logic posQ, ovrQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      magQ <= '0;
      posQ <= 1'b0;
      ovrQ <= 1'b0;
    end else if (ctrl.capture) begin
      magQ <= resMag;
      posQ <= resPos;
      ovrQ <= resOvr;
    end else if (ctrl.expire) begin
      magQ <= '0;
      posQ <= 1'b0;
      ovrQ <= 1'b0;
    end
  end

  logic [HI_W-1:0]  hiBits;
  logic [BUS_W-1:0] byteSel;
  assign hiBits = magQ[MAG_W-1:BUS_W];

  always_comb begin
    unique case (ctrl.kind)
      KIND_LO:     byteSel = magQ[BUS_W-1:0];
      KIND_HI_OVR: byteSel = {ovrQ, hiBits};
      default:     byteSel = {posQ, hiBits};
    endcase
  end

  assign dataOe  = ctrl.busOe;
  assign dataOut = ctrl.busOe ? byteSel : '0;

  // R6
  capture_loads_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.capture |=> (magQ == $past(resMag)) && (posQ == $past(resPos)) && (ovrQ == $past(resOvr)));

  // R7
  expire_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.expire && !ctrl.capture) |=> (magQ == '0) && !posQ && !ovrQ);

endmodule

// File: rtl/conv_result_bus.sv
module conv_result_bus
  import conv_bus_pkg::*;
#(
  parameter int BUS_W         = 8,
  parameter int MAG_W         = 15,
  parameter int SYNC_STAGES   = 2,
  parameter int EXPIRE_CYCLES = 443
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             resultValid,
  input  logic [MAG_W-1:0] resultMag,
  input  logic             resultPos,
  input  logic             resultOvr,
  input  logic             csHi,
  input  logic             ceN,
  input  logic             rdN,
  input  logic             contMode,
  input  logic             byteSelLo,
  input  logic             dbSelOvr,
  output logic [BUS_W-1:0] dataOut,
  output logic             dataOe
);

  busCtrl_t ctrl;

  bus_seq_ctrl #(
    .SYNC_STAGES  (SYNC_STAGES),
    .EXPIRE_CYCLES(EXPIRE_CYCLES)
  ) i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .resultValid(resultValid),
    .csHi       (csHi),
    .ceN        (ceN),
    .rdN        (rdN),
    .contMode   (contMode),
    .byteSelLo  (byteSelLo),
    .dbSelOvr   (dbSelOvr),
    .ctrl       (ctrl)
  );

  bus_result_dp #(
    .BUS_W(BUS_W),
    .MAG_W(MAG_W)
  ) i_dp (
    .clk    (clk),
    .rstN   (rstN),
    .ctrl   (ctrl),
    .resMag (resultMag),
    .resPos (resultPos),
    .resOvr (resultOvr),
    .dataOut(dataOut),
    .dataOe (dataOe)
  );

  // R1
  idle_bus_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !dataOe |-> dataOut == '0);

endmodule

// File: tb/test_conv_result_bus.sv
`timescale 1ns/1ps
module test_conv_result_bus;

  localparam int SYNC = 2;
  localparam int EXP  = 443;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic resultValid = 1'b0;
  logic [14:0] resultMag = '0;
  logic resultPos = 1'b0, resultOvr = 1'b0;
  logic csHi = 1'b0, ceN = 1'b1, rdN = 1'b1, contMode = 1'b0, byteSelLo = 1'b0, dbSelOvr = 1'b0;
  logic [7:0] dataOut;
  logic dataOe;

  always #10 clk = ~clk;

  conv_result_bus i_conv_result_bus (
    .clk(clk), .rstN(rstN), .resultValid(resultValid), .resultMag(resultMag),
    .resultPos(resultPos), .resultOvr(resultOvr), .csHi(csHi), .ceN(ceN), .rdN(rdN),
    .contMode(contMode), .byteSelLo(byteSelLo), .dbSelOvr(dbSelOvr),
    .dataOut(dataOut), .dataOe(dataOe)
  );

  int nTests = 0, nFail = 0, cyc = 0;
  string curReq = "R9";

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [5:0] mPipe[$];
  logic [14:0] mMag = '0;
  logic mPos = 0, mOvr = 0, mLive = 0, mRdPrev = 1;
  int mIdx = 0, mAge = 0;

  initial begin
    for (int i = 0; i < SYNC; i++) mPipe.push_back(6'b011000);
  end

  always @(posedge clk) begin
    if (!rstN) begin
      mPipe.delete();
      for (int i = 0; i < SYNC; i++) mPipe.push_back(6'b011000);
      mMag = '0; mPos = 0; mOvr = 0; mLive = 0; mRdPrev = 1; mIdx = 0; mAge = 0;
    end else begin
      logic [5:0] s;
      logic sel, rise, expire;
      s = mPipe[0];
      sel = s[5] & ~s[4];
      rise = s[3] & ~mRdPrev & sel & s[2];
      expire = mLive && (mAge >= EXP - 1) && s[2];
      if (resultValid) begin
        mMag = resultMag; mPos = resultPos; mOvr = resultOvr;
        mIdx = 0; mLive = 1; mAge = 0;
      end else if (expire) begin
        mMag = '0; mPos = 0; mOvr = 0; mIdx = 0; mLive = 0;
      end else begin
        if (rise) mIdx = (mIdx + 1) % 3;
        if (mLive) mAge++;
      end
      mRdPrev = s[3];
      mPipe.push_back({csHi, ceN, rdN, contMode, byteSelLo, dbSelOvr});
      void'(mPipe.pop_front());
    end
  end

  function automatic logic [8:0] modelOut();
    logic [5:0] s;
    int kind;
    logic [7:0] b;
    s = mPipe[0];
    if (!(s[5] & ~s[4] & ~s[3])) return 9'h000;
    kind = s[2] ? mIdx : (s[1] ? 1 : (s[0] ? 2 : 0));
    case (kind)
      0:       b = {mPos, mMag[14:8]};
      1:       b = mMag[7:0];
      default: b = {mOvr, mMag[14:8]};
    endcase
    return {1'b1, b};
  endfunction

  always @(negedge clk) begin
    logic [8:0] e;
    e = modelOut();
    chk({curReq, " oe"}, {7'd0, dataOe}, {7'd0, e[8]});
    chk({curReq, " data"}, dataOut, e[7:0]);
  end

  // ---------------- watchdog ----------------
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nFail++; nTests++;
      $display("FAIL watchdog act=running exp=finished");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  task automatic waitN(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic capture(logic [14:0] m, logic p, logic o);
    @(negedge clk);
    resultValid = 1; resultMag = m; resultPos = p; resultOvr = o;
    @(negedge clk);
    resultValid = 0;
  endtask

  task automatic readByte(output logic [7:0] v);
    @(negedge clk); rdN = 0;
    waitN(3);
    v = dataOut;
    rdN = 1;
    waitN(3);
  endtask

  logic [7:0] v;

  initial begin
    waitN(3);
    // R9 reset state
    chk("R9 oe", {7'd0, dataOe}, 8'd0);
    chk("R9 data", dataOut, 8'h00);
    rstN = 1;
    waitN(2);

    // addressed style
    curReq = "R2";
    capture(15'h5A3C, 1'b1, 1'b0);
    csHi = 1; ceN = 0; byteSelLo = 1;
    readByte(v); chk("R2 low byte", v, 8'h3C);
    curReq = "R3";
    byteSelLo = 0; dbSelOvr = 0;
    readByte(v); chk("R3 high sign", v, 8'hDA);
    dbSelOvr = 1;
    readByte(v); chk("R3 high overrange", v, 8'h5A);

    // R1 enable gating
    curReq = "R1";
    ceN = 1;
    readByte(v); chk("R1 ceN high", v, 8'h00);
    ceN = 0; csHi = 0;
    @(negedge clk); rdN = 0; waitN(3);
    chk("R1 cs low oe", {7'd0, dataOe}, 8'd0);
    rdN = 1; waitN(3);
    csHi = 1;

    // R8 latency
    curReq = "R8";
    @(negedge clk); rdN = 0;
    @(negedge clk); chk("R8 one edge", {7'd0, dataOe}, 8'd0);
    @(negedge clk); chk("R8 two edges", {7'd0, dataOe}, 8'd1);
    rdN = 1; waitN(4);

    // streaming style
    curReq = "R4";
    contMode = 1;
    waitN(3);
    capture(15'h1234, 1'b0, 1'b1);
    byteSelLo = 1; dbSelOvr = 0;
    readByte(v); chk("R4 first", v, 8'h12);
    byteSelLo = 0; dbSelOvr = 1;
    readByte(v); chk("R4 second", v, 8'h34);
    byteSelLo = 1;
    readByte(v); chk("R4 third", v, 8'h92);
    readByte(v); chk("R4 wrap", v, 8'h12);

    // R5 no advance when deselected or held
    curReq = "R5";
    csHi = 0;
    @(negedge clk); rdN = 0; waitN(4); rdN = 1; waitN(4);
    csHi = 1; waitN(3);
    readByte(v); chk("R5 deselected pulse ignored", v, 8'h34);
    @(negedge clk); rdN = 0; waitN(20);
    chk("R5 held read", dataOut, 8'h92);
    rdN = 1; waitN(4);
    readByte(v); chk("R5 after release", v, 8'h12);

    // R6 new latch restarts order
    curReq = "R6";
    capture(15'h7F01, 1'b1, 1'b0);
    readByte(v); chk("R6 restart first", v, 8'hFF);
    readByte(v); chk("R6 restart second", v, 8'h01);

    // R7 expiry in streaming style
    curReq = "R7";
    waitN(EXP + 5);
    readByte(v); chk("R7 expired first", v, 8'h00);
    readByte(v); chk("R7 expired second", v, 8'h00);
    readByte(v); chk("R7 expired third", v, 8'h00);

    // R7 no expiry in addressed style
    contMode = 0; waitN(3);
    capture(15'h0155, 1'b0, 1'b1);
    waitN(EXP + 150);
    byteSelLo = 1;
    readByte(v); chk("R7 addressed held low", v, 8'h55);
    byteSelLo = 0; dbSelOvr = 1;
    readByte(v); chk("R7 addressed held high", v, 8'h81);

    waitN(4);
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

endmodule